// File: doc/BRIEF.md
# Wrapping Register Stack

This block is a last-in, first-out store built from a small array of registers inside the core. It holds 64 words of 8 bits by default. A client issues push requests with a data word, or pop requests, and the block returns each popped word one cycle later on a registered output. A single stack pointer tracks the top of the stack. The full and empty states come from that pointer returning to zero, so the block needs no limit registers and no separate occupancy counter.

The first word pushed after reset goes to slot 1. Each further push moves one slot higher, and the pointer wraps at the top of the array, so the last word that fits lands in slot 0. A pop reads the top word and then moves the pointer down. A request that would overflow or underflow the stack is refused. It changes nothing in the stack and produces a one-cycle error pulse.

Top module: `reg_stack`

## Requirements
- R1: While synchronous reset `rst_n` is low, and in the first cycle after it is released, the outputs read `sp_o` = 0, `empty_o` = 1, `full_o` = 0, `err_o` = 0 and `dout_o` = 0.
- R2: An accepted push (`push_i` = 1, `pop_i` = 0, `full_o` = 0) adds one to `sp_o`, modulo the depth, writes `din_i` at the new pointer value and clears `empty_o`. These effects are visible after the clock edge.
- R3: An accepted pop (`pop_i` = 1, `empty_o` = 0) reads the word at the current `sp_o`, subtracts one from `sp_o` modulo the depth and clears `full_o`.
- R4: `full_o` rises exactly when an accepted push wraps `sp_o` to 0. The first word pushed from empty lands at slot 1, and the 64th lands at slot 0.
- R5: `empty_o` rises exactly when an accepted pop brings `sp_o` to 0.
- R6: A push while `full_o` = 1 is rejected. `sp_o`, the flags and the stored words stay unchanged, and `err_o` is 1 for the following cycle only.
- R7: A pop while `empty_o` = 1 is rejected. `sp_o`, the flags and `dout_o` stay unchanged, and `err_o` is 1 for the following cycle only.
- R8: When `push_i` and `pop_i` are both 1, the pop is handled and the push is ignored. This holds even when the pop itself is rejected.
- R9: A popped word appears on `dout_o` in the cycle after the pop is accepted. `dout_o` holds its value in every cycle without an accepted pop.
- R10: `full_o` and `empty_o` are never 1 at the same time, and either one being set implies `sp_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request; wins over push |
| din_i | input | 8 | Word to push |
| dout_o | output | 8 | Last popped word, registered |
| sp_o | output | 6 | Stack pointer, the slot holding the top word |
| full_o | output | 1 | Every slot is in use |
| empty_o | output | 1 | No slot is in use |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
Pointer and flag faults show up at the ports one clock after the faulty request, as a wrong `sp_o` or flag value. A stored word written to the wrong slot stays hidden until it is popped, possibly many cycles later. The bench therefore fills the stack completely and drains it again, so every slot is read back. It also runs a long mixed stream of requests, checked against a behavioural model on every cycle, which exposes misplaced words as soon as they reach `dout_o`. Refused requests at both wrap points are followed by a full drain, which proves the stored words were untouched.

// File: rtl/rstk_pkg.sv
// Shared types for the register stack.
// Assumes: nothing beyond standard SystemVerilog.
package rstk_pkg;
    // Decoded request kind for one cycle.
    typedef enum logic [2:0] {
        RQ_IDLE     = 3'd0,
        RQ_PUSH     = 3'd1,
        RQ_POP      = 3'd2,
        RQ_PUSH_REJ = 3'd3,
        RQ_POP_REJ  = 3'd4
    } rq_kind_t;
endpackage

// File: rtl/rstk_ctrl.sv
// Pointer and flag control for the register stack.
// It decodes each request and moves the pointer: up before a write, down after a read.
// Full and empty are set only when the pointer wraps to zero.
// Assumes: DEPTH is a power of two, so the pointer wraps naturally.
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] sp_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          err_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o
);
    localparam logic [AW-1:0] PTR_ONE  = AW'(1);
    localparam logic [AW-1:0] PTR_ZERO = '0;

    logic [AW-1:0] sp_q;
    logic          full_q;
    logic          empty_q;
    logic          err_q;
    logic [AW-1:0] sp_up;
    logic [AW-1:0] sp_dn;
    rq_kind_t      kind;

    assign sp_up = sp_q + PTR_ONE;
    assign sp_dn = sp_q - PTR_ONE;

    // Classify the request; pop has priority over push.
    always_comb begin
        kind = RQ_IDLE;
        if (pop_i) begin
            kind = empty_q ? RQ_POP_REJ : RQ_POP;
        end else if (push_i) begin
            kind = full_q ? RQ_PUSH_REJ : RQ_PUSH;
        end
    end

    // Update the pointer, the flags and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= PTR_ZERO;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (kind)
                RQ_PUSH: begin
                    sp_q    <= sp_up;
                    full_q  <= (sp_up == PTR_ZERO);
                    empty_q <= 1'b0;
                end
                RQ_POP: begin
                    sp_q    <= sp_dn;
                    empty_q <= (sp_dn == PTR_ZERO);
                    full_q  <= 1'b0;
                end
                RQ_PUSH_REJ, RQ_POP_REJ: err_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign sp_o      = sp_q;
    assign full_o    = full_q;
    assign empty_o   = empty_q;
    assign err_o     = err_q;
    assign wr_en_o   = (kind == RQ_PUSH);
    assign wr_addr_o = sp_up;
    assign rd_en_o   = (kind == RQ_POP);
    assign rd_addr_o = sp_q;

    // An accepted push advances the pointer and clears empty.
    assert_push_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + PTR_ONE) && !empty_o);

    // An accepted pop moves the pointer back and clears full.
    assert_pop_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> (sp_o == $past(sp_o) - PTR_ONE) && !full_o);

    // Full is set only at the wrap point of the pointer.
    assert_full_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (sp_o == PTR_ZERO));

    // Empty is set only at the wrap point of the pointer.
    assert_empty_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (sp_o == PTR_ZERO));

    // A push into a full stack changes nothing and pulses the error.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o));

    // A pop from an empty stack changes nothing and pulses the error, even with a push present.
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> err_o && empty_o && $stable(sp_o));

    // The error lasts a single cycle unless another bad request arrives.
    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(pop_i && empty_o) && !(push_i && !pop_i && full_o)) |=> !err_o);

    // Full and empty are mutually exclusive.
    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
endmodule

// File: rtl/rstk_store.sv
// Storage array for the register stack.
// It has one write port and one registered read port.
// Assumes: the write and read enables are never both set in one cycle.
module rstk_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write the pushed word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            slot_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Capture the popped word; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            rd_q <= slot_q[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;

    // The output changes only after an accepted pop.
    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    // Reads and writes are never requested together.
    assert_port_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));
endmodule

// File: rtl/reg_stack.sv
// Top level of the wrapping register stack.
// It joins the pointer and flag control to the storage array.
// Assumes: DEPTH is a power of two and at least 2.
module reg_stack #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic [DATA_W-1:0]        din_i,
    output logic [DATA_W-1:0]        dout_o,
    output logic [$clog2(DEPTH)-1:0] sp_o,
    output logic                     full_o,
    output logic                     empty_o,
    output logic                     err_o
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    rstk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .sp_o      (sp_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .err_o     (err_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr)
    );

    rstk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (din_i),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (dout_o)
    );

    // Reset state is visible on the outputs the cycle after reset is released.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (sp_o == '0) && empty_o && !full_o && !err_o && (dout_o == '0));
endmodule

// File: tb/reg_stack_tb_top.sv
`timescale 1ns/1ps
// Bench for reg_stack. A behavioural reference model is updated at every rising edge.
// All outputs are compared against the model at every falling edge.
module reg_stack_tb_top;
    localparam int DW = 8;
    localparam int DP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic [5:0]    sp_o;
    logic          full_o, empty_o, err_o;

    int vectors = 0;
    int fails = 0;

    // Reference model state
    int m_mem [DP];
    int m_sp = 0;
    bit m_full = 0, m_empty = 1, m_err = 0;
    int m_dout = 0;

    always #2 clk = ~clk;

    reg_stack #(.DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
        .dout_o(dout_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    // Advance the model by one clock edge with the given request.
    task automatic model_edge(input bit rs, input bit pu, input bit po, input int d);
        if (rs) begin
            m_sp = 0; m_full = 0; m_empty = 1; m_err = 0; m_dout = 0;
        end else if (po) begin
            if (m_empty) m_err = 1;
            else begin
                m_err = 0;
                m_dout = m_mem[m_sp];
                m_sp = (m_sp + DP - 1) % DP;
                m_empty = (m_sp == 0);
                m_full = 0;
            end
        end else if (pu) begin
            if (m_full) m_err = 1;
            else begin
                m_err = 0;
                m_sp = (m_sp + 1) % DP;
                m_mem[m_sp] = d;
                m_full = (m_sp == 0);
                m_empty = 0;
            end
        end else m_err = 0;
    endtask

    // Compare all outputs with the model.
    task automatic compare(input string rq);
        vectors++;
        if (sp_o !== 6'(m_sp) || full_o !== m_full || empty_o !== m_empty ||
            err_o !== m_err || dout_o !== DW'(m_dout)) begin
            fails++;
            $display("FAIL %s: sp=%0d full=%0b empty=%0b err=%0b dout=%0d, expected sp=%0d full=%0b empty=%0b err=%0b dout=%0d",
                     rq, sp_o, full_o, empty_o, err_o, dout_o,
                     m_sp, m_full, m_empty, m_err, m_dout);
        end
    endtask

    // Drive one cycle at the falling edge, then compare at the next falling edge.
    task automatic step(input bit pu, input bit po, input int d, input string rq);
        push_i = pu; pop_i = po; din_i = DW'(d);
        @(posedge clk);
        model_edge(!rst_n, pu, po, d);
        @(negedge clk);
        compare(rq);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int lfsr;
        @(negedge clk);
        // R1: reset state while reset is held and right after it is released
        step(1, 0, 8'hAA, "R1");
        step(0, 1, 0, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, "R1");

        // R7: pop on empty is rejected; R8: a push alongside it is ignored
        step(0, 1, 0, "R7");
        step(0, 0, 0, "R7");
        step(1, 1, 8'h11, "R8");
        step(0, 0, 0, "R8");

        // R2, R4: fill all slots; the first word goes to slot 1 and the wrap sets full
        for (int i = 0; i < DP; i++) step(1, 0, (i * 7 + 3) & 8'hFF, "R4");
        // R6: pushes into a full stack are rejected
        step(1, 0, 8'hEE, "R6");
        step(1, 0, 8'hDD, "R6");
        step(0, 0, 0, "R6");
        // R8: push and pop together on a full stack, so the pop wins
        step(1, 1, 8'hCC, "R8");
        step(1, 0, 8'h5A, "R2");
        // R3, R5, R9: drain everything, checking LIFO order and the empty flag at the wrap
        for (int i = 0; i < DP; i++) step(0, 1, 0, "R3");
        // R9: the output holds through idle cycles
        step(0, 0, 0, "R9");
        step(0, 0, 0, "R9");
        step(1, 0, 8'h42, "R9");
        step(0, 0, 0, "R9");
        step(0, 1, 0, "R5");
        step(0, 1, 0, "R7");

        // R10: long mixed stream of requests
        lfsr = 32'h1ACE;
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step(lfsr[0] | lfsr[4], lfsr[1] & (i % 300 > 150 ? 1 : lfsr[3]),
                 (lfsr >> 5) & 8'hFF, "R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule